// File: doc/BRIEF.md
# Semaphore-Driven Descriptor Chain Sequencer

This block sequences the commands of one DMA channel. Commands are descriptors held in a small local memory. Each descriptor holds three things: a pointer to the next descriptor, a chain bit, and two per-command flags. One flag asks for a semaphore decrement and the other asks for a completion interrupt. The data movement itself happens outside the block. For each command the sequencer presents the descriptor's address on a request/done handshake and waits for the executor to report completion.

Software drives the block through a small register port. It loads the address of the first descriptor and adds a count to an 8-bit hardware semaphore. It then opens the channel's gate bit. The channel fetches and executes commands while three conditions hold: the gate is open, the semaphore is nonzero, and a chain is armed. The semaphore therefore counts the commands that are still outstanding. When more commands are appended during a run, software adds only the count of the new commands.

The state machine has four states. IDLE waits for work. FETCH issues the descriptor read. DECODE latches the returned word. EXEC holds the request until done. Its transitions are:
- T_START: IDLE to FETCH when the channel is armed, ungated and the semaphore is nonzero.
- T_READ: FETCH to DECODE.
- T_ISSUE: DECODE to EXEC.
- T_RETIRE: EXEC to IDLE on done.
- T_HALT: any state to IDLE on gate or channel reset.

Top module: `dcs_chain_seq`

## Requirements
- R1: After reset, exec_req, desc_rd and irq are 0, the semaphore reads 0, the gate bit reads 1 (channel gated) and the interrupt register reads 0.
- R2: Register offsets are: 0 control, 1 control-set, 2 control-clear, 4 interrupt, 5 interrupt-set, 6 interrupt-clear, 8 next-descriptor address, 12 semaphore. Control bit 0 is the gate and control bit 1 is the channel reset (write-only, reads 0). Interrupt bit 0 is the completion status and interrupt bit 1 is the enable. A write to a set or clear alias changes only the bits written as 1.
- R3: The channel fetches only when three conditions hold: the gate is 0, the semaphore is nonzero, and the chain has been armed by a write to offset 8. The first fetch reads the address written there. desc_rd rises in the cycle after the channel becomes eligible, and desc_data is expected one cycle after desc_rd.
- R4: Descriptor word layout: bits [7:0] next address, bit 8 chain, bit 9 decrement, bit 10 interrupt flag. exec_req stays high with exec_addr steady, equal to the descriptor's own address, until exec_done is sampled high.
- R5: A completed command lowers the semaphore by one only when its decrement bit is set.
- R6: On completion of a chained command the pointer moves to the next address, and offset 8 reads that address. Execution stops while the semaphore is 0 and resumes at that pointer once the semaphore is written nonzero.
- R7: After a command without the chain bit completes, the channel stays idle, even if the semaphore is still nonzero, until offset 8 is written again.
- R8: A write to offset 12 adds its low 8 bits to the semaphore, saturating at 255. A decrement in the same cycle is applied after the addition. A decrement at 0 is ignored.
- R9: Setting the gate drops exec_req within one cycle, and a command aborted this way does not decrement. Clearing the gate refetches the same descriptor.
- R10: A completion whose interrupt flag is set sets the status bit, even when the enable is 0. irq is high exactly when both status and enable are 1. Status is cleared through the clear alias.
- R11: Writing 1 to control bit 1 returns the channel to IDLE: the semaphore becomes 0, exec_req drops the next cycle and the chain is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| desc_rd | output | 1 | Descriptor memory read strobe |
| desc_addr | output | 8 | Descriptor memory read address |
| desc_data | input | 11 | Descriptor word, valid one cycle after desc_rd |
| exec_req | output | 1 | Command execute request |
| exec_addr | output | 8 | Address of the descriptor being executed |
| exec_done | input | 1 | Executor completion, sampled while exec_req is high |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume two things about the inputs: exec_done is only meaningful while exec_req is high, and descriptor memory answers exactly one cycle after desc_rd. The hold check on exec_addr also assumes that software does not rewrite the next-descriptor address in the middle of a command. The stimulus follows all of these rules. Its memory model returns data on the clock after each read. Its executor pulses done only in a cycle where it sees the request. The pointer is written only while the channel is idle, gated or disarmed.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_DECODE = 2'd2,
        ST_EXEC   = 2'd3
    } dcs_state_e;

    localparam logic [3:0] OFS_CTRL     = 4'd0;
    localparam logic [3:0] OFS_CTRL_SET = 4'd1;
    localparam logic [3:0] OFS_CTRL_CLR = 4'd2;
    localparam logic [3:0] OFS_IRQ      = 4'd4;
    localparam logic [3:0] OFS_IRQ_SET  = 4'd5;
    localparam logic [3:0] OFS_IRQ_CLR  = 4'd6;
    localparam logic [3:0] OFS_NEXT     = 4'd8;
    localparam logic [3:0] OFS_SEMA     = 4'd12;

    localparam int BIT_GATE   = 0;
    localparam int BIT_CHRST  = 1;
    localparam int BIT_STATUS = 0;
    localparam int BIT_IRQEN  = 1;

endpackage

// File: rtl/dcs_regs.sv
module dcs_regs
    import dcs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SEMA_W = 8,
    localparam int WD_W  = (ADDR_W > SEMA_W) ? ADDR_W : SEMA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [WD_W-1:0]   reg_wdata,
    output logic [WD_W-1:0]   reg_rdata,
    input  logic [SEMA_W-1:0] sema,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cmpl_irq,
    output logic              gate,
    output logic              chan_rst,
    output logic              irq_en,
    output logic              irq_status,
    output logic              nxt_wr,
    output logic [ADDR_W-1:0] nxt_data,
    output logic              sema_wr,
    output logic [SEMA_W-1:0] sema_add
);

    logic wr_ctrl, wr_ctrl_set, wr_ctrl_clr;
    logic wr_irq, wr_irq_set, wr_irq_clr;

    always_comb begin
        wr_ctrl     = reg_wr && (reg_addr == OFS_CTRL);
        wr_ctrl_set = reg_wr && (reg_addr == OFS_CTRL_SET);
        wr_ctrl_clr = reg_wr && (reg_addr == OFS_CTRL_CLR);
        wr_irq      = reg_wr && (reg_addr == OFS_IRQ);
        wr_irq_set  = reg_wr && (reg_addr == OFS_IRQ_SET);
        wr_irq_clr  = reg_wr && (reg_addr == OFS_IRQ_CLR);
        nxt_wr      = reg_wr && (reg_addr == OFS_NEXT);
        sema_wr     = reg_wr && (reg_addr == OFS_SEMA);
        nxt_data    = reg_wdata[ADDR_W-1:0];
        sema_add    = reg_wdata[SEMA_W-1:0];
        chan_rst    = (wr_ctrl || wr_ctrl_set) && reg_wdata[BIT_CHRST];
    end

    // gate and enable follow the plain / set / clear aliases
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate   <= 1'b1;
            irq_en <= 1'b0;
        end else begin
            if (wr_ctrl)
                gate <= reg_wdata[BIT_GATE];
            else if (wr_ctrl_set && reg_wdata[BIT_GATE])
                gate <= 1'b1;
            else if (wr_ctrl_clr && reg_wdata[BIT_GATE])
                gate <= 1'b0;

            if (wr_irq)
                irq_en <= reg_wdata[BIT_IRQEN];
            else if (wr_irq_set && reg_wdata[BIT_IRQEN])
                irq_en <= 1'b1;
            else if (wr_irq_clr && reg_wdata[BIT_IRQEN])
                irq_en <= 1'b0;
        end
    end

    // a hardware completion wins over a software clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_status <= 1'b0;
        else if (cmpl_irq)
            irq_status <= 1'b1;
        else if (wr_irq)
            irq_status <= reg_wdata[BIT_STATUS];
        else if (wr_irq_set && reg_wdata[BIT_STATUS])
            irq_status <= 1'b1;
        else if (wr_irq_clr && reg_wdata[BIT_STATUS])
            irq_status <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: reg_rdata[BIT_GATE] = gate;
            OFS_IRQ: begin
                reg_rdata[BIT_STATUS] = irq_status;
                reg_rdata[BIT_IRQEN]  = irq_en;
            end
            OFS_NEXT: reg_rdata[ADDR_W-1:0] = cur_addr;
            OFS_SEMA: reg_rdata[SEMA_W-1:0] = sema;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dcs_sema.sv
module dcs_sema #(
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add_en,
    input  logic [SEMA_W-1:0] add_val,
    input  logic              dec,
    output logic [SEMA_W-1:0] count,
    output logic              nonzero
);

    localparam logic [SEMA_W-1:0] SAT_MAX = '1;

    logic [SEMA_W:0]   sum;
    logic [SEMA_W-1:0] added;
    logic [SEMA_W-1:0] count_d;

    always_comb begin
        sum   = {1'b0, count} + {1'b0, (add_en ? add_val : '0)};
        added = sum[SEMA_W] ? SAT_MAX : sum[SEMA_W-1:0];
        if (dec && (added != '0))
            count_d = added - 1'b1;
        else
            count_d = added;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else
            count <= count_d;
    end

    assign nonzero = (count != '0);

endmodule

// File: rtl/dcs_fsm.sv
module dcs_fsm
    import dcs_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int DESC_W = ADDR_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate,
    input  logic              chan_rst,
    input  logic              sema_nz,
    input  logic              nxt_wr,
    input  logic [ADDR_W-1:0] nxt_data,
    input  logic [DESC_W-1:0] desc_data,
    input  logic              exec_done,
    output logic              desc_rd,
    output logic              exec_req,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              dec_pulse,
    output logic              cmpl_irq,
    output dcs_state_e        state
);

    localparam int POS_CHAIN = ADDR_W;
    localparam int POS_DEC   = ADDR_W + 1;
    localparam int POS_IRQ   = ADDR_W + 2;

    dcs_state_e        state_d;
    logic              armed;
    logic              halt;
    logic              retire;
    logic [DESC_W-1:0] cmd_q;

    assign halt   = gate || chan_rst;
    assign retire = (state == ST_EXEC) && exec_done && !halt;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:   if (!halt && armed && sema_nz) state_d = ST_FETCH; // T_START
            ST_FETCH:  state_d = halt ? ST_IDLE : ST_DECODE;              // T_READ / T_HALT
            ST_DECODE: state_d = halt ? ST_IDLE : ST_EXEC;                // T_ISSUE / T_HALT
            ST_EXEC:   if (halt || exec_done) state_d = ST_IDLE;          // T_HALT / T_RETIRE
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        desc_rd   = (state == ST_FETCH);
        exec_req  = (state == ST_EXEC);
        dec_pulse = retire && cmd_q[POS_DEC];
        cmpl_irq  = retire && cmd_q[POS_IRQ];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (state == ST_DECODE) begin
            cmd_q <= desc_data;
        end
    end

    // pointer and arm flag: software write wins over a retiring command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            armed    <= 1'b0;
        end else if (chan_rst) begin
            armed <= 1'b0;
        end else if (nxt_wr) begin
            cur_addr <= nxt_data;
            armed    <= 1'b1;
        end else if (retire) begin
            if (cmd_q[POS_CHAIN])
                cur_addr <= cmd_q[ADDR_W-1:0];
            else
                armed <= 1'b0;
        end
    end

endmodule

// File: rtl/dcs_chain_seq.sv
module dcs_chain_seq
    import dcs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SEMA_W = 8
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          reg_wr,
    input  logic [3:0]                                    reg_addr,
    input  logic [((ADDR_W > SEMA_W) ? ADDR_W : SEMA_W)-1:0] reg_wdata,
    output logic [((ADDR_W > SEMA_W) ? ADDR_W : SEMA_W)-1:0] reg_rdata,
    output logic                                          desc_rd,
    output logic [ADDR_W-1:0]                             desc_addr,
    input  logic [ADDR_W+2:0]                             desc_data,
    output logic                                          exec_req,
    output logic [ADDR_W-1:0]                             exec_addr,
    input  logic                                          exec_done,
    output logic                                          irq
);

    logic              gate, chan_rst, irq_en, irq_status;
    logic              nxt_wr, sema_wr, sema_nz;
    logic              dec_pulse, cmpl_irq;
    logic [ADDR_W-1:0] nxt_data, cur_addr;
    logic [SEMA_W-1:0] sema_add, sema;
    dcs_state_e        state;

    dcs_regs #(.ADDR_W(ADDR_W), .SEMA_W(SEMA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .sema(sema), .cur_addr(cur_addr), .cmpl_irq(cmpl_irq),
        .gate(gate), .chan_rst(chan_rst),
        .irq_en(irq_en), .irq_status(irq_status),
        .nxt_wr(nxt_wr), .nxt_data(nxt_data),
        .sema_wr(sema_wr), .sema_add(sema_add)
    );

    dcs_sema #(.SEMA_W(SEMA_W)) u_sema (
        .clk(clk), .rst_n(rst_n),
        .clear(chan_rst), .add_en(sema_wr), .add_val(sema_add),
        .dec(dec_pulse), .count(sema), .nonzero(sema_nz)
    );

    dcs_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .gate(gate), .chan_rst(chan_rst), .sema_nz(sema_nz),
        .nxt_wr(nxt_wr), .nxt_data(nxt_data),
        .desc_data(desc_data), .exec_done(exec_done),
        .desc_rd(desc_rd), .exec_req(exec_req), .cur_addr(cur_addr),
        .dec_pulse(dec_pulse), .cmpl_irq(cmpl_irq), .state(state)
    );

    assign desc_addr = cur_addr;
    assign exec_addr = cur_addr;
    assign irq       = irq_status && irq_en;

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker
    import dcs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SEMA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gate,
    input logic              chan_rst,
    input logic              nxt_wr,
    input logic              sema_wr,
    input logic              dec_pulse,
    input logic [SEMA_W-1:0] sema,
    input dcs_state_e        state,
    input logic              desc_rd,
    input logic              exec_req,
    input logic              exec_done,
    input logic [ADDR_W-1:0] exec_addr,
    input logic              irq_en,
    input logic              irq
);

    a_r9_gate_halts: assert property (@(posedge clk) disable iff (!rst_n)
        gate |=> !exec_req);

    a_r11_reset_idles: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (sema == '0 && !exec_req && state == ST_IDLE));

    a_r5_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_pulse && !sema_wr && !chan_rst && sema != '0)
        |=> (sema == SEMA_W'($past(sema) - 1'b1)));

    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (sema == '0 && !sema_wr) |=> (sema == '0));

    a_r3_idle_without_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && sema == '0) |=> !desc_rd);

    a_r4_request_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_req && !exec_done && !gate && !chan_rst && !nxt_wr)
        |=> (exec_req && $stable(exec_addr)));

    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

endmodule

bind dcs_chain_seq dcs_checker #(.ADDR_W(ADDR_W), .SEMA_W(SEMA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gate(gate), .chan_rst(chan_rst),
    .nxt_wr(nxt_wr), .sema_wr(sema_wr), .dec_pulse(dec_pulse),
    .sema(sema), .state(state), .desc_rd(desc_rd),
    .exec_req(exec_req), .exec_done(exec_done), .exec_addr(exec_addr),
    .irq_en(irq_en), .irq(irq)
);

// File: tb/sim_dcs_chain_seq.sv
module sim_dcs_chain_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        desc_rd;
    logic [7:0]  desc_addr;
    logic [10:0] desc_data = '0;
    logic        exec_req;
    logic [7:0]  exec_addr;
    logic        exec_done;
    logic        irq;
    logic        mon_done = 1'b0;
    logic        man_done = 1'b0;
    logic        auto_mode = 1'b1;
    logic [10:0] mem [256];
    logic [7:0]  exp_q [$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          ended = 0;

    assign exec_done = mon_done | man_done;

    always #5 clk = ~clk;

    dcs_chain_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .desc_rd(desc_rd),
        .desc_addr(desc_addr), .desc_data(desc_data), .exec_req(exec_req),
        .exec_addr(exec_addr), .exec_done(exec_done), .irq(irq)
    );

    // descriptor memory: data one cycle after the read strobe
    always @(posedge clk) if (desc_rd) desc_data <= mem[desc_addr];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected command and acknowledges it
    always @(negedge clk) begin
        if (mon_done) begin
            mon_done = 1'b0;
        end else if (auto_mode && exec_req) begin
            if (exp_q.size() == 0)
                chk(0, "R4 unexpected command", exec_addr, 0);
            else
                chk(exec_addr == exp_q.pop_front(), "R4/R6 command order", exec_addr, 0);
            mon_done = 1'b1;
        end
    end

    task automatic expect_cmd(input logic [7:0] a);
        exp_q.push_back(a);
    endtask

    function automatic logic [10:0] mk(input logic [7:0] nxt, input bit ch, input bit dc, input bit iq);
        return {iq, dc, ch, nxt};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic drain(input string tag);
        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic wait_exec();
        int n = 0;
        do begin @(negedge clk); n++; end while (!exec_req && n < 100);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[8'h10] = mk(8'h20, 1, 1, 0);
        mem[8'h20] = mk(8'h30, 1, 1, 0);
        mem[8'h30] = mk(8'h00, 0, 1, 1);
        mem[8'h40] = mk(8'h41, 1, 1, 0);
        mem[8'h41] = mk(8'h42, 1, 1, 0);
        mem[8'h42] = mk(8'h00, 0, 1, 0);
        mem[8'h50] = mk(8'h51, 1, 0, 0);
        mem[8'h51] = mk(8'h00, 0, 1, 0);
        mem[8'h60] = mk(8'h00, 0, 1, 0);
        mem[8'h70] = mk(8'h00, 0, 1, 0);
        mem[8'h80] = mk(8'h00, 0, 1, 0);
        mem[8'h90] = mk(8'h00, 0, 1, 0);
        mem[8'hA0] = mk(8'h00, 0, 1, 1);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd0, v);  chk(v == 8'h01, "R1 control after reset", v, 1);
        rd(4'd12, v); chk(v == 8'h00, "R1 semaphore after reset", v, 0);
        rd(4'd4, v);  chk(v == 8'h00, "R1 interrupt reg after reset", v, 0);
        chk(!exec_req && !desc_rd && !irq, "R1 outputs idle", {exec_req, desc_rd, irq}, 0);

        // R3/R6/R5 three-command chain, then R10 interrupt
        wr(4'd5, 8'h02);
        wr(4'd8, 8'h10);
        wr(4'd12, 8'd3);
        repeat (5) @(negedge clk);
        chk(!desc_rd && !exec_req, "R3 gated channel stays idle", desc_rd, 0);
        expect_cmd(8'h10); expect_cmd(8'h20); expect_cmd(8'h30);
        wr(4'd2, 8'h01);
        drain("R6 chain fully walked");
        rd(4'd12, v); chk(v == 8'd0, "R5 semaphore after chain", v, 0);
        chk(irq == 1'b1, "R10 irq after flagged completion", irq, 1);
        rd(4'd4, v); chk(v == 8'h03, "R10 status and enable", v, 3);
        wr(4'd6, 8'h01);
        chk(irq == 1'b0, "R10 irq cleared", irq, 0);
        rd(4'd4, v); chk(v == 8'h02, "R2 clear alias keeps enable", v, 2);

        // R6 stop at zero, resume on new count
        wr(4'd8, 8'h40);
        expect_cmd(8'h40);
        wr(4'd12, 8'd1);
        drain("R6 only one command with count 1");
        rd(4'd8, v); chk(v == 8'h41, "R6 pointer advanced", v, 8'h41);
        expect_cmd(8'h41); expect_cmd(8'h42);
        wr(4'd12, 8'd2);
        drain("R6 resumed chain");
        rd(4'd12, v); chk(v == 8'd0, "R6 semaphore after resume", v, 0);

        // R5 command without decrement flag
        wr(4'd8, 8'h50);
        expect_cmd(8'h50); expect_cmd(8'h51);
        wr(4'd12, 8'd1);
        drain("R5 non-decrementing command continues");
        rd(4'd12, v); chk(v == 8'd0, "R5 semaphore after 0x51", v, 0);

        // R7 non-chained end with count left
        wr(4'd8, 8'h60);
        expect_cmd(8'h60);
        wr(4'd12, 8'd3);
        drain("R7 stops after unchained command");
        rd(4'd12, v); chk(v == 8'd2, "R7 count left", v, 2);
        expect_cmd(8'h60);
        wr(4'd8, 8'h60);
        drain("R7 rerun after pointer write");
        rd(4'd12, v); chk(v == 8'd1, "R7 count after rerun", v, 1);
        expect_cmd(8'h60);
        wr(4'd8, 8'h60);
        drain("R7 second rerun");

        // R8 saturation, R11 reset
        wr(4'd1, 8'h01);
        wr(4'd12, 8'd200);
        wr(4'd12, 8'd100);
        rd(4'd12, v); chk(v == 8'd255, "R8 saturation", v, 255);
        wr(4'd1, 8'h02);
        rd(4'd12, v); chk(v == 8'd0, "R11 reset clears semaphore", v, 0);
        rd(4'd0, v); chk(v == 8'h01, "R2 reset bit leaves gate set", v, 1);

        // R8 write and decrement in the same cycle
        auto_mode = 1'b0;
        wr(4'd8, 8'h70);
        wr(4'd12, 8'd2);
        wr(4'd2, 8'h01);
        wait_exec();
        chk(exec_addr == 8'h70, "R4 manual command address", exec_addr, 8'h70);
        man_done = 1'b1; reg_wr = 1'b1; reg_addr = 4'd12; reg_wdata = 8'd5;
        @(negedge clk);
        man_done = 1'b0; reg_wr = 1'b0;
        rd(4'd12, v); chk(v == 8'd6, "R8 add then decrement", v, 6);
        wr(4'd1, 8'h02);

        // R9 gate abort and refetch
        wr(4'd8, 8'h80);
        wr(4'd12, 8'd1);
        wait_exec();
        wr(4'd1, 8'h01);
        @(negedge clk);
        chk(exec_req == 1'b0, "R9 gate drops request", exec_req, 0);
        rd(4'd12, v); chk(v == 8'd1, "R9 aborted command keeps count", v, 1);
        wr(4'd2, 8'h01);
        wait_exec();
        chk(exec_req && exec_addr == 8'h80, "R9 refetch same descriptor", exec_addr, 8'h80);
        man_done = 1'b1;
        @(negedge clk);
        man_done = 1'b0;
        rd(4'd12, v); chk(v == 8'd0, "R9 count after refetch", v, 0);

        // R11 reset during a command
        wr(4'd8, 8'h90);
        wr(4'd12, 8'd3);
        wait_exec();
        wr(4'd1, 8'h02);
        chk(exec_req == 1'b0, "R11 request dropped", exec_req, 0);
        rd(4'd12, v); chk(v == 8'd0, "R11 semaphore zero", v, 0);
        wr(4'd12, 8'd1);
        begin
            bit seen = 0;
            repeat (20) begin @(negedge clk); if (desc_rd || exec_req) seen = 1; end
            chk(!seen, "R11 chain disarmed", seen, 0);
        end
        wr(4'd1, 8'h02);
        auto_mode = 1'b1;

        // R10 status without enable
        wr(4'd6, 8'h03);
        wr(4'd8, 8'hA0);
        expect_cmd(8'hA0);
        wr(4'd12, 8'd1);
        drain("R10 flagged command ran");
        rd(4'd4, v); chk(v == 8'h01, "R10 status set while disabled", v, 1);
        chk(irq == 1'b0, "R10 irq masked", irq, 0);
        wr(4'd5, 8'h02);
        chk(irq == 1'b1, "R10 irq after enable", irq, 1);
        wr(4'd6, 8'h01);
        rd(4'd4, v); chk(v == 8'h02 && !irq, "R2 status cleared enable kept", v, 2);

        finish_run();
    end

endmodule